// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register set of a simple asynchronous serial port. A single-cycle register bus reads and writes byte registers inside a small address window. Writes to the transmit data register leave the block as a one-cycle byte strobe toward a transmitter. Received bytes arrive through a valid/ready handshake and wait in a receive FIFO until software reads them. Bit timing, shifting and interrupt routing are handled elsewhere.

The status register holds five flags: transmit complete, transmit buffer empty, line break, receive buffer full and receive data present. Software clears a flag by writing a 0 to its bit. A build parameter selects either the plain variant or the FIFO variant. In the FIFO variant some bits of the mode and control registers are reserved and read back as zero.

Reads return data in the same cycle as the access (combinational `bus_rdata`). Their side effects, a FIFO pop or a status refresh, take effect at the clock edge that ends the access.

Top module: `serial_regif`

## Requirements
- R1: After reset, status reads 0x60, control reads 0x20, mode reads 0x00, port control reads 0x00, `tx_valid` is low and `rx_ready` is high.
- R2: Register offsets are: mode 0x00, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, port control 0x20 (fully writable, reads back). Any other offset reads 0, ignores writes and raises `bus_err` for exactly the one cycle after the access. Transmit data reads 0. Writes to receive data are ignored without error.
- R3: With `FIFO_VARIANT`=1, mode writes are masked with 0x7B and control writes with 0xFB. With `FIFO_VARIANT`=0, all 8 bits are stored.
- R4: Status bit layout: bit 6 transmit complete, bit 5 transmit empty, bit 4 break, bit 1 receive full, bit 0 data ready. All other bits read 0.
- R5: A status write clears each flag whose bit is written 0. Flags written 1 keep their value.
- R6: A transmit data write makes `tx_valid` high for exactly the next cycle with `tx_data` equal to the written byte, and clears transmit empty.
- R7: A control write with bit 5 equal to 0 sets transmit complete.
- R8: A status read while control bit 5 is 1 returns bits 6 and 5 as 1, and leaves both flags set afterwards.
- R9: The receive FIFO accepts a byte on each cycle with `rx_valid` and `rx_ready` both high, holds up to `RX_DEPTH` (16) bytes, drops `rx_ready` while full, and sets receive full once it is full.
- R10: A receive data read returns the oldest byte and removes it. A read of an empty FIFO returns 0.
- R11: Data ready is set whenever the FIFO is non-empty, and clears only when a status write with bit 0 equal to 0 happens while the FIFO is empty.
- R12: A one-cycle pulse on `rx_break` sets the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access |
| bus_err | output | 1 | Pulse after an access to an unmapped offset |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive FIFO can accept |
| rx_break | input | 1 | Line break event pulse |

## Verification
The assertions assume at most one bus access per cycle, and an address held stable for that cycle. They also assume that `rx_valid` is only meaningful while `rx_ready` is high, since no byte is taken otherwise. The stimulus drives a single access per clock from one task, keeps `bus_sel` low during reset, and only raises `rx_valid` for one cycle at a time. A push attempted against a full FIFO is deliberate: it checks that the byte is refused rather than breaking the handshake assumption.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;

  localparam logic [7:0] OFF_MODE  = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_TXD   = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_RXD   = 8'h14;
  localparam logic [7:0] OFF_PCTL  = 8'h20;

  // status bit positions seen by software
  localparam int SB_TEND = 6;
  localparam int SB_TDE  = 5;
  localparam int SB_BRK  = 4;
  localparam int SB_RXF  = 1;
  localparam int SB_DR   = 0;

  // control bit: transmitter enable
  localparam int CB_TXEN = 5;

  // internal flag vector indices
  localparam int FL_DR   = 0;
  localparam int FL_RXF  = 1;
  localparam int FL_BRK  = 2;
  localparam int FL_TDE  = 3;
  localparam int FL_TEND = 4;
  localparam int NFLAGS  = 5;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  function automatic logic [7:0] mode_mask(input bit fifo_v);
    return fifo_v ? 8'h7B : 8'hFF;
  endfunction

  function automatic logic [7:0] ctrl_mask(input bit fifo_v);
    return fifo_v ? 8'hFB : 8'hFF;
  endfunction

endpackage

// File: rtl/serial_rst_sync.sv
module serial_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/serial_addr_dec.sv
module serial_addr_dec
  import serial_regif_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mode,
  output logic              hit_ctrl,
  output logic              hit_txd,
  output logic              hit_stat,
  output logic              hit_rxd,
  output logic              hit_pctl,
  output logic              miss
);
  always_comb begin
    hit_mode = sel && (addr == OFF_MODE[ADDR_W-1:0]);
    hit_ctrl = sel && (addr == OFF_CTRL[ADDR_W-1:0]);
    hit_txd  = sel && (addr == OFF_TXD[ADDR_W-1:0]);
    hit_stat = sel && (addr == OFF_STAT[ADDR_W-1:0]);
    hit_rxd  = sel && (addr == OFF_RXD[ADDR_W-1:0]);
    hit_pctl = sel && (addr == OFF_PCTL[ADDR_W-1:0]);
    miss     = sel && !(hit_mode || hit_ctrl || hit_txd ||
                        hit_stat || hit_rxd || hit_pctl);
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; the write enable is the accepted push
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
  import serial_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic              stat_rd,
  input  logic [7:0]        wdata,
  input  logic              txd_wr,
  input  logic              ctrl_wr,
  input  logic              tx_enabled,
  input  logic              brk_evt,
  input  logic              rx_nonempty,
  input  logic              rx_full,
  output logic [NFLAGS-1:0] flags,
  output logic [7:0]        stat_view
);
  logic [NFLAGS-1:0] fl_q, fl_d;
  logic              force_tx;

  assign force_tx = tx_enabled;

  always_comb begin
    fl_d = fl_q;
    if (stat_wr) begin
      if (!wdata[SB_TEND]) fl_d[FL_TEND] = 1'b0;
      if (!wdata[SB_TDE])  fl_d[FL_TDE]  = 1'b0;
      if (!wdata[SB_BRK])  fl_d[FL_BRK]  = 1'b0;
      if (!wdata[SB_RXF])  fl_d[FL_RXF]  = 1'b0;
      if (!wdata[SB_DR])   fl_d[FL_DR]   = 1'b0;
    end
    if (txd_wr) fl_d[FL_TDE] = 1'b0;
    if (ctrl_wr && !wdata[CB_TXEN]) fl_d[FL_TEND] = 1'b1;
    if (stat_rd && force_tx) begin
      fl_d[FL_TDE]  = 1'b1;
      fl_d[FL_TEND] = 1'b1;
    end
    if (brk_evt)     fl_d[FL_BRK] = 1'b1;
    if (rx_nonempty) fl_d[FL_DR]  = 1'b1;
    if (rx_full)     fl_d[FL_RXF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q <= '0;
      fl_q[FL_TEND] <= 1'b1;
      fl_q[FL_TDE]  <= 1'b1;
    end else begin
      fl_q <= fl_d;
    end
  end

  always_comb begin
    stat_view          = '0;
    stat_view[SB_TEND] = fl_q[FL_TEND] | force_tx;
    stat_view[SB_TDE]  = fl_q[FL_TDE]  | force_tx;
    stat_view[SB_BRK]  = fl_q[FL_BRK];
    stat_view[SB_RXF]  = fl_q[FL_RXF];
    stat_view[SB_DR]   = fl_q[FL_DR];
  end

  assign flags = fl_q;
endmodule

// File: rtl/serial_regif.sv
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter bit FIFO_VARIANT = 1'b1,
  parameter int RX_DEPTH     = 16,
  parameter int ADDR_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              rx_break
);
  localparam int CNT_W = $clog2(RX_DEPTH+1);

  logic rst_sync_n;
  logic hit_mode, hit_ctrl, hit_txd, hit_stat, hit_rxd, hit_pctl, miss;
  logic wr, rd;
  logic [7:0] mode_q, mode_d, ctrl_q, ctrl_d, pctl_q, pctl_d;
  logic       txv_q, txv_d, err_q, err_d;
  logic [7:0] txd_q, txd_d;
  logic [7:0] mmask, cmask;
  logic [7:0] rx_head;
  logic       rx_empty, rx_full;
  logic [CNT_W-1:0] rx_count;
  logic [NFLAGS-1:0] flag_q;
  logic [7:0] stat_view;

  serial_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  serial_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .addr(bus_addr),
    .hit_mode(hit_mode), .hit_ctrl(hit_ctrl), .hit_txd(hit_txd),
    .hit_stat(hit_stat), .hit_rxd(hit_rxd), .hit_pctl(hit_pctl),
    .miss(miss)
  );

  assign wr = bus_we;
  assign rd = !bus_we;

  generate
    if (FIFO_VARIANT) begin : g_fifo_masks
      assign mmask = mode_mask(1'b1);
      assign cmask = ctrl_mask(1'b1);
    end else begin : g_plain_masks
      assign mmask = mode_mask(1'b0);
      assign cmask = ctrl_mask(1'b0);
    end
  endgenerate

  serial_rx_fifo #(.DEPTH(RX_DEPTH), .DATA_W(8)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n),
    .push(rx_valid), .push_data(rx_data),
    .pop(hit_rxd && rd),
    .head(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  assign rx_ready = !rx_full;

  serial_status_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .stat_wr(hit_stat && wr), .stat_rd(hit_stat && rd),
    .wdata(bus_wdata),
    .txd_wr(hit_txd && wr), .ctrl_wr(hit_ctrl && wr),
    .tx_enabled(ctrl_q[CB_TXEN]),
    .brk_evt(rx_break), .rx_nonempty(!rx_empty), .rx_full(rx_full),
    .flags(flag_q), .stat_view(stat_view)
  );

  // next state
  always_comb begin
    mode_d = mode_q;
    ctrl_d = ctrl_q;
    pctl_d = pctl_q;
    txd_d  = txd_q;
    txv_d  = 1'b0;
    err_d  = miss;
    if (wr && hit_mode) mode_d = bus_wdata & mmask;
    if (wr && hit_ctrl) ctrl_d = bus_wdata & cmask;
    if (wr && hit_pctl) pctl_d = bus_wdata;
    if (wr && hit_txd) begin
      txd_d = bus_wdata;
      txv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
      ctrl_q <= CTRL_RESET;
      pctl_q <= '0;
      txd_q  <= '0;
      txv_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ctrl_q <= ctrl_d;
      pctl_q <= pctl_d;
      txd_q  <= txd_d;
      txv_q  <= txv_d;
      err_q  <= err_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (1'b1)
        hit_mode: bus_rdata = mode_q;
        hit_ctrl: bus_rdata = ctrl_q;
        hit_stat: bus_rdata = stat_view;
        hit_rxd:  bus_rdata = rx_head;
        hit_pctl: bus_rdata = pctl_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;
  assign bus_err  = err_q;
endmodule

// File: rtl/serial_regif_chk.sv
module serial_regif_chk
  import serial_regif_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int ADDR_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_err,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              rx_ready,
  input logic [$clog2(RX_DEPTH+1)-1:0] fifo_cnt,
  input logic [NFLAGS-1:0] flags
);
  // R6
  tx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_sel && bus_we && bus_addr == OFF_TXD[ADDR_W-1:0]));

  // R6
  tx_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_data == $past(bus_wdata));

  // R6
  tde_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !flags[FL_TDE]);

  // R2
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(RX_DEPTH+1))'(RX_DEPTH));

  // R9
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> $stable(fifo_cnt) || fifo_cnt < $past(fifo_cnt));

  // R11
  dr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt != '0) |=> flags[FL_DR]);
endmodule

bind serial_regif serial_regif_chk #(.RX_DEPTH(RX_DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_err(bus_err),
  .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready),
  .fifo_cnt(rx_count), .flags(flag_q)
);

// File: tb/serial_regif_test.sv
module serial_regif_test;
  logic       clk;
  logic       rst_n;
  logic       bus_sel, bus_we;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_err, tx_valid, rx_valid, rx_ready, rx_break;
  logic [7:0] tx_data, rx_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [7:0] tx_expq[$];
  logic [7:0] rx_model[$];

  serial_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_break(rx_break)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // scoreboard monitor for transmit strobes (R6)
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (tx_expq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R6: unexpected tx byte 0x%02h expected none", tx_data);
      end else begin
        check("R6", tx_data, tx_expq.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input bit exp_err = 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 6'h0C) tx_expq.push_back(d);
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
    check("R2", {7'd0, bus_err}, {7'd0, exp_err});
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] d, input bit exp_err = 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
    check("R2", {7'd0, bus_err}, {7'd0, exp_err});
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    #1 check("R9", {7'd0, rx_ready}, {7'd0, rx_model.size() < 16});
    if (rx_model.size() < 16) rx_model.push_back(d);
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic rx_pop_chk;
    logic [7:0] exp;
    exp = (rx_model.size() == 0) ? 8'h00 : rx_model.pop_front();
    rd_chk("R10", 6'h14, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_break = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check("R1", {7'd0, tx_valid}, 8'h00);
    check("R1", {7'd0, rx_ready}, 8'h01);
    rd_chk("R1", 6'h10, 8'h60);
    rd_chk("R1", 6'h08, 8'h20);
    rd_chk("R1", 6'h00, 8'h00);
    rd_chk("R1", 6'h20, 8'h00);

    // R3 write masks (FIFO variant)
    bus_write(6'h00, 8'hFF); rd_chk("R3", 6'h00, 8'h7B);
    bus_write(6'h08, 8'hFF); rd_chk("R3", 6'h08, 8'hFB);

    // R8 forced view while transmitter enabled, flags kept afterwards
    bus_write(6'h0C, 8'h41);
    rd_chk("R8", 6'h10, 8'h60);
    bus_write(6'h08, 8'h00);
    rd_chk("R8", 6'h10, 8'h60);

    // R6 transmit clears empty flag; R4 layout
    bus_write(6'h0C, 8'h5A);
    rd_chk("R6", 6'h10, 8'h40);
    rd_chk("R2", 6'h0C, 8'h00);

    // R5 / R7
    bus_write(6'h10, 8'hBF); rd_chk("R5", 6'h10, 8'h00);
    bus_write(6'h08, 8'h00); rd_chk("R7", 6'h10, 8'h40);
    bus_write(6'h10, 8'hFF); rd_chk("R5", 6'h10, 8'h40);
    bus_write(6'h08, 8'h20); rd_chk("R8", 6'h10, 8'h60);
    bus_write(6'h08, 8'h00); rd_chk("R4", 6'h10, 8'h60);

    // R12 break
    @(negedge clk); rx_break = 1; @(negedge clk); rx_break = 0;
    rd_chk("R12", 6'h10, 8'h70);
    bus_write(6'h10, 8'hFF); rd_chk("R5", 6'h10, 8'h70);
    bus_write(6'h10, 8'hEF); rd_chk("R5", 6'h10, 8'h60);

    // R9..R11 small burst
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    rd_chk("R11", 6'h10, 8'h61);
    bus_write(6'h10, 8'hFE); rd_chk("R11", 6'h10, 8'h61);
    repeat (3) rx_pop_chk();
    rx_pop_chk();
    rd_chk("R11", 6'h10, 8'h61);
    bus_write(6'h10, 8'hFE); rd_chk("R11", 6'h10, 8'h60);

    // R9 fill to capacity and beyond
    for (int i = 0; i < 17; i++) rx_push(8'hA0 + 8'(i));
    check("R9", {7'd0, rx_ready}, 8'h00);
    rd_chk("R9", 6'h10, 8'h63);
    bus_write(6'h10, 8'hFC); rd_chk("R9", 6'h10, 8'h63);
    for (int i = 0; i < 17; i++) rx_pop_chk();
    check("R9", {7'd0, rx_ready}, 8'h01);
    rd_chk("R11", 6'h10, 8'h63);
    bus_write(6'h10, 8'hFC); rd_chk("R11", 6'h10, 8'h60);

    // R2 map and unmapped offsets
    bus_write(6'h20, 8'h5A); rd_chk("R2", 6'h20, 8'h5A);
    bus_read(6'h24, v, 1); check("R2", v, 8'h00);
    bus_read(6'h3C, v, 1); check("R2", v, 8'h00);
    bus_write(6'h04, 8'hFF, 1);
    bus_write(6'h18, 8'h00, 1);
    bus_write(6'h14, 8'h99);
    rd_chk("R2", 6'h10, 8'h60);
    rd_chk("R2", 6'h00, 8'h7B);
    rd_chk("R2", 6'h14, 8'h00);
    @(negedge clk);
    check("R2", {7'd0, bus_err}, 8'h00);

    repeat (3) @(posedge clk);
    check("R6", 8'(tx_expq.size()), 8'h00);
    finish_run();
  end
endmodule